// File: doc/BRIEF.md
# Voice Recorder Serial Command Port

This block is the serial control front end of a message record and playback device. A host drives a four-wire serial link (active-low select, serial clock, data in, data out); the block samples those pins with its own fast system clock, assembles a 24-bit command frame sent least-significant bit first, and returns a status frame on the data-out pin during the same transfer. Status and a new command can therefore travel in one frame.

When the select line returns high, the block decodes the five control bits at the tail of the frame and issues exactly one single-cycle strobe to the row sequencer behind it: power up, power down, play or record from a given row, play or record from the current row, start or resume message cueing, or stop. A separate load strobe, together with the captured 16-bit address, tells the sequencer to move its row counter. The sequencer reports overflow and end-of-message events back as pulses; the block keeps them as sticky interrupt flags, ships them out in the next status frame, and clears them when that frame begins.

The serial clock must idle low and run at no more than one eighth of the system clock, since every pin passes through a two-stage synchronizer and an edge detector.

Top module: `rec_ctl_port`

## Requirements
- R1: After reset all command strobes and loadAddr are 0, misoEn is 0 and intPending is 0.
- R2: A frame is the data-in bits sampled on the rising serial-clock edges while select is low; frame bit 0 is the first bit sent. Bits 0..15 are the address (bit 0 = address LSB), bits 16..18 are ignored, bits 19..23 are control bits K0..K4 (K0 = cue, K1 = keep current row, K2 = power on, K3 = play when 1 / record when 0, K4 = run).
- R3: The status frame sent on misoData is, in order, the overflow flag, the end-of-message flag, rowPtr bit 0 up to bit 15, then six zeros; it is captured at frame start and advances one bit after each falling serial-clock edge (serial clock idles low).
- R4: misoEn is 0 whenever select has been high for the last three system clocks, and 1 during a frame.
- R5: Command strobes appear only after select rises, last one system clock, and at most one fires per frame.
- R6: With K0..K4 written as a string, 00100 gives power-up, 00111 set-play, 01111 play, 00101 set-record, 01101 record, 10111 set-cue, 11111 cue, 011x0 stop, and any frame with K2 = 0 gives power-down.
- R7: loadAddr pulses, with addrOut equal to frame bits 0..15, together with set-play, set-record and set-cue only (K1 = 0 and K4 = 1); with K1 = 1 no load occurs.
- R8: The cue bit is ignored on record frames: 10101 gives set-record and 11101 gives record.
- R9: An ovfIn or eomIn pulse sets its sticky flag and raises intPending; both flags clear at the start of the next frame, after their values are captured into the status frame.
- R10: A frame whose bit count is not 24 issues no strobe and no load, but still clears the interrupt flags; the next correct frame decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ssN | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from host, idles low |
| mosi | input | 1 | Serial data from host |
| misoData | output | 1 | Serial status data to host |
| misoEn | output | 1 | Output enable for the data-out pad driver |
| ovfIn | input | 1 | Overflow event pulse from sequencer |
| eomIn | input | 1 | End-of-message event pulse from sequencer |
| rowPtr | input | 16 | Current row pointer from sequencer |
| cmdPowerUp | output | 1 | Power-up strobe |
| cmdPowerDown | output | 1 | Stop and power-down strobe |
| cmdSetPlay | output | 1 | Play from loaded address strobe |
| cmdPlay | output | 1 | Play from current row strobe |
| cmdSetRec | output | 1 | Record from loaded address strobe |
| cmdRec | output | 1 | Record from current row strobe |
| cmdSetCue | output | 1 | Cue from loaded address strobe |
| cmdCue | output | 1 | Cue from current row strobe |
| cmdStop | output | 1 | Stop strobe |
| loadAddr | output | 1 | Row counter load strobe |
| addrOut | output | 16 | Address captured from the frame |
| intPending | output | 1 | Interrupt request, high while a flag is set |

## Verification
The bench walks every control encoding, including the cue bit paired with record and the power-off pattern with stray bits, so a decoder that ranks the power bit below run or honours cue during record emits the wrong strobe. It reads each of the 24 returned bits against an independently built status word under changing row pointers, catching a frame that starts one bit late or puts the two flags in swapped order. Frames of 20 and 25 bits must produce no strobe yet still clear a pending interrupt, which exposes a counter that wraps or an interrupt clear tied to a good frame instead of to frame start. A design that captured the flags after clearing them would return zeros in the first two status bits after an event.

// File: rtl/rcp_pkg.sv
package rcp_pkg;
  localparam int ADDR_W  = 16;
  localparam int PAD_W   = 3;
  localparam int CTL_W   = 5;
  localparam int FRAME_W = ADDR_W + PAD_W + CTL_W;
  localparam int STAT_W  = 2 + ADDR_W;
  localparam int ZERO_W  = FRAME_W - STAT_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int SYNC_N  = 3;

  // control bit positions within the control field
  localparam int K_CUE  = 0;
  localparam int K_KEEP = 1;
  localparam int K_PWR  = 2;
  localparam int K_PLAY = 3;
  localparam int K_RUN  = 4;

  typedef struct packed {
    logic frameStart;
    logic frameEnd;
    logic sampleBit;
    logic shiftOut;
  } dpCtl_t;

  typedef struct packed {
    logic powerUp;
    logic powerDown;
    logic setPlay;
    logic play;
    logic setRec;
    logic rec;
    logic setCue;
    logic cue;
    logic stop;
  } cmdStrobe_t;
endpackage

// File: rtl/rcp_sync.sv
module rcp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg <= {STAGES{RST_VAL}};
    else       stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rcp_control.sv
module rcp_control
  import rcp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ssN,
  input  logic             sclk,
  input  logic             mosi,
  input  logic [CTL_W-1:0] ctlBits,
  output dpCtl_t           dpCtl,
  output logic             mosiBit,
  output logic             misoEn,
  output cmdStrobe_t       cmd,
  output logic             loadAddr
);
  localparam logic [SYNC_N-1:0] SYNC_RST = 3'b001;
  localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0]  CNT_OK   = CNT_W'(FRAME_W);

  logic [SYNC_N-1:0] rawPins, syncPins;
  assign rawPins = {mosi, sclk, ssN};

  for (genvar i = 0; i < SYNC_N; i++) begin : g_sync
    rcp_sync #(.STAGES(2), .RST_VAL(SYNC_RST[i])) u_sync (
      .clk (clk),
      .rstN(rstN),
      .d   (rawPins[i]),
      .q   (syncPins[i])
    );
  end

  logic ssS, sclkS, ssPrev, sclkPrev;
  assign ssS     = syncPins[0];
  assign sclkS   = syncPins[1];
  assign mosiBit = syncPins[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ssPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      ssPrev   <= ssS;
      sclkPrev <= sclkS;
    end
  end

  logic ssFall, ssRise, sclkRise, sclkFall;
  assign ssFall   = ssPrev & ~ssS;
  assign ssRise   = ~ssPrev & ssS;
  assign sclkRise = ~sclkPrev & sclkS & ~ssS;
  assign sclkFall = sclkPrev & ~sclkS & ~ssS;

  logic [CNT_W-1:0] bitCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             bitCnt <= '0;
    else if (ssFall)                       bitCnt <= '0;
    else if (sclkRise && bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
  end

  logic frameOk;
  assign frameOk = (bitCnt == CNT_OK);

  assign dpCtl.frameStart = ssFall;
  assign dpCtl.frameEnd   = ssRise & frameOk;
  assign dpCtl.sampleBit  = sclkRise;
  assign dpCtl.shiftOut   = sclkFall;
  assign misoEn           = ~ssS;

  cmdStrobe_t cmdNext;
  logic       loadNext;
  logic       kCue, kKeep, kPwr, kPlay, kRun;
  assign kCue  = ctlBits[K_CUE];
  assign kKeep = ctlBits[K_KEEP];
  assign kPwr  = ctlBits[K_PWR];
  assign kPlay = ctlBits[K_PLAY];
  assign kRun  = ctlBits[K_RUN];

  always_comb begin
    cmdNext  = '0;
    loadNext = 1'b0;
    if (dpCtl.frameEnd) begin
      if (!kPwr) begin
        cmdNext.powerDown = 1'b1;
      end else if (!kRun) begin
        if (kKeep) cmdNext.stop    = 1'b1;
        else       cmdNext.powerUp = 1'b1;
      end else if (kPlay) begin
        if (kCue) begin
          if (kKeep) cmdNext.cue    = 1'b1;
          else       cmdNext.setCue = 1'b1;
        end else begin
          if (kKeep) cmdNext.play    = 1'b1;
          else       cmdNext.setPlay = 1'b1;
        end
      end else begin
        if (kKeep) cmdNext.rec    = 1'b1;
        else       cmdNext.setRec = 1'b1;
      end
      loadNext = kPwr & kRun & ~kKeep;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmd      <= '0;
      loadAddr <= 1'b0;
    end else begin
      cmd      <= cmdNext;
      loadAddr <= loadNext;
    end
  end
endmodule

// File: rtl/rcp_datapath.sv
module rcp_datapath
  import rcp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic              mosiBit,
  input  logic              ovfIn,
  input  logic              eomIn,
  input  logic [ADDR_W-1:0] rowPtr,
  output logic [CTL_W-1:0]  ctlBits,
  output logic [ADDR_W-1:0] addrOut,
  output logic              misoData,
  output logic              intPending
);
  logic [FRAME_W-1:0] inReg, outReg;
  logic               ovfFlag, eomFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                inReg <= '0;
    else if (dpCtl.sampleBit) inReg <= {mosiBit, inReg[FRAME_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 outReg <= '0;
    else if (dpCtl.frameStart) outReg <= {{ZERO_W{1'b0}}, rowPtr, eomFlag, ovfFlag};
    else if (dpCtl.shiftOut)   outReg <= {1'b0, outReg[FRAME_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      eomFlag <= 1'b0;
    end else begin
      ovfFlag <= (ovfFlag & ~dpCtl.frameStart) | ovfIn;
      eomFlag <= (eomFlag & ~dpCtl.frameStart) | eomIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               addrOut <= '0;
    else if (dpCtl.frameEnd) addrOut <= inReg[ADDR_W-1:0];
  end

  assign ctlBits    = inReg[FRAME_W-1 -: CTL_W];
  assign misoData   = outReg[0];
  assign intPending = ovfFlag | eomFlag;
endmodule

// File: rtl/rec_ctl_port.sv
module rec_ctl_port
  import rcp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ssN,
  input  logic              sclk,
  input  logic              mosi,
  output logic              misoData,
  output logic              misoEn,
  input  logic              ovfIn,
  input  logic              eomIn,
  input  logic [ADDR_W-1:0] rowPtr,
  output logic              cmdPowerUp,
  output logic              cmdPowerDown,
  output logic              cmdSetPlay,
  output logic              cmdPlay,
  output logic              cmdSetRec,
  output logic              cmdRec,
  output logic              cmdSetCue,
  output logic              cmdCue,
  output logic              cmdStop,
  output logic              loadAddr,
  output logic [ADDR_W-1:0] addrOut,
  output logic              intPending
);
  dpCtl_t           dpCtl;
  cmdStrobe_t       cmd;
  logic             mosiBit;
  logic [CTL_W-1:0] ctlBits;

  rcp_control u_control (
    .clk     (clk),
    .rstN    (rstN),
    .ssN     (ssN),
    .sclk    (sclk),
    .mosi    (mosi),
    .ctlBits (ctlBits),
    .dpCtl   (dpCtl),
    .mosiBit (mosiBit),
    .misoEn  (misoEn),
    .cmd     (cmd),
    .loadAddr(loadAddr)
  );

  rcp_datapath u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .dpCtl     (dpCtl),
    .mosiBit   (mosiBit),
    .ovfIn     (ovfIn),
    .eomIn     (eomIn),
    .rowPtr    (rowPtr),
    .ctlBits   (ctlBits),
    .addrOut   (addrOut),
    .misoData  (misoData),
    .intPending(intPending)
  );

  assign cmdPowerUp   = cmd.powerUp;
  assign cmdPowerDown = cmd.powerDown;
  assign cmdSetPlay   = cmd.setPlay;
  assign cmdPlay      = cmd.play;
  assign cmdSetRec    = cmd.setRec;
  assign cmdRec       = cmd.rec;
  assign cmdSetCue    = cmd.setCue;
  assign cmdCue       = cmd.cue;
  assign cmdStop      = cmd.stop;
endmodule

// File: rtl/rec_ctl_port_chk.sv
module rec_ctl_port_chk (
  input logic        clk,
  input logic        rstN,
  input logic        ssN,
  input logic        sclk,
  input logic        mosi,
  input logic        misoData,
  input logic        misoEn,
  input logic        ovfIn,
  input logic        eomIn,
  input logic [15:0] rowPtr,
  input logic        cmdPowerUp,
  input logic        cmdPowerDown,
  input logic        cmdSetPlay,
  input logic        cmdPlay,
  input logic        cmdSetRec,
  input logic        cmdRec,
  input logic        cmdSetCue,
  input logic        cmdCue,
  input logic        cmdStop,
  input logic        loadAddr,
  input logic [15:0] addrOut,
  input logic        intPending
);
  logic [8:0] cmdVec;
  assign cmdVec = {cmdPowerUp, cmdPowerDown, cmdSetPlay, cmdPlay, cmdSetRec,
                   cmdRec, cmdSetCue, cmdCue, cmdStop};

  assert_one_cmd_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdVec));

  assert_cmd_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|cmdVec) |=> !(|cmdVec));

  assert_cmd_after_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|cmdVec) |-> !misoEn);

  assert_miso_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ssN && $past(ssN) && $past(ssN, 2)) |-> !misoEn);

  assert_load_only_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    loadAddr |-> (cmdSetPlay || cmdSetRec || cmdSetCue));

  assert_set_has_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdSetPlay || cmdSetRec || cmdSetCue) |-> loadAddr);

  assert_int_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ovfIn || eomIn) |=> intPending);

  assert_int_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intPending) |-> misoEn);
endmodule

bind rec_ctl_port rec_ctl_port_chk u_chk (.*);

// File: tb/test_rec_ctl_port.sv
module test_rec_ctl_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ssN = 1'b1;
  logic        sclk = 1'b0;
  logic        mosi = 1'b0;
  logic        ovfIn = 1'b0;
  logic        eomIn = 1'b0;
  logic [15:0] rowPtr = '0;
  logic        misoData, misoEn, loadAddr, intPending;
  logic        cmdPowerUp, cmdPowerDown, cmdSetPlay, cmdPlay, cmdSetRec;
  logic        cmdRec, cmdSetCue, cmdCue, cmdStop;
  logic [15:0] addrOut;

  int checks = 0;
  int fails  = 0;
  logic [25:0] expQ[$];

  always #2.5 clk = ~clk;

  rec_ctl_port i_rec_ctl_port (.*);

  // bit order: powerUp powerDown setPlay play setRec rec setCue cue stop
  function automatic logic [9:0] expCmd(input logic [4:0] k);
    logic [4:0] s;
    s = {k[0], k[1], k[2], k[3], k[4]};  // written as K0..K4
    casez (s)
      5'b00100: return {9'b100000000, 1'b0};
      5'b00111: return {9'b001000000, 1'b1};
      5'b01111: return {9'b000100000, 1'b0};
      5'b?0101: return {9'b000010000, 1'b1};
      5'b?1101: return {9'b000001000, 1'b0};
      5'b10111: return {9'b000000100, 1'b1};
      5'b11111: return {9'b000000010, 1'b0};
      5'b011?0: return {9'b000000001, 1'b0};
      5'b??0??: return {9'b010000000, 1'b0};
      default:  return 10'b0;
    endcase
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
  endtask

  // sends a frame; status bits read before each rising edge
  task automatic sendFrame(input logic [15:0] addr, input logic [2:0] pad,
                           input logic [4:0] k, input int nBits,
                           input logic [23:0] expStat, input string req);
    logic [23:0] frm;
    logic [9:0]  e;
    frm = {k, pad, addr};
    if (nBits == 24) begin
      e = expCmd(k);
      expQ.push_back({e, addr});
    end
    ssN = 1'b0;
    waitClk(8);
    #1 check(misoEn === 1'b1, "R4", 32'(misoEn), 1);
    for (int i = 0; i < nBits; i++) begin
      mosi = (i < 24) ? frm[i] : 1'b1;
      waitClk(8);
      #1 check(misoData === ((i < 24) ? expStat[i] : 1'b0), "R3",
               32'(misoData), 32'((i < 24) ? expStat[i] : 1'b0));
      sclk = 1'b1;
      waitClk(8);
      sclk = 1'b0;
    end
    waitClk(8);
    ssN = 1'b1;
    waitClk(12);
    #1 check(misoEn === 1'b0, req, 32'(misoEn), 0);
  endtask

  function automatic logic [23:0] stat(input logic ovf, input logic eom);
    return {6'b0, rowPtr, eom, ovf};
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    logic [8:0] act;
    logic [25:0] e;
    act = {cmdPowerUp, cmdPowerDown, cmdSetPlay, cmdPlay, cmdSetRec, cmdRec,
           cmdSetCue, cmdCue, cmdStop};
    if (rstN && (|act || loadAddr)) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 unexpected strobe actual=%0h expected=0", {act, loadAddr});
      end else begin
        e = expQ.pop_front();
        check(act === e[25:17], "R6", 32'(act), 32'(e[25:17]));
        check(loadAddr === e[16], "R7", 32'(loadAddr), 32'(e[16]));
        if (e[16]) check(addrOut === e[15:0], "R2", 32'(addrOut), 32'(e[15:0]));
      end
    end
  end

  task automatic finishRun();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    waitClk(200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    waitClk(5);
    #1;
    check({cmdPowerUp, cmdPowerDown, cmdSetPlay, cmdPlay, cmdSetRec, cmdRec,
           cmdSetCue, cmdCue, cmdStop, loadAddr} === 10'b0, "R1", 0, 0);
    check(misoEn === 1'b0, "R1", 32'(misoEn), 0);
    check(intPending === 1'b0, "R1", 32'(intPending), 0);
    rstN = 1'b1;
    waitClk(4);

    // R2 R6 R7: address frames, don't-care bits varied
    rowPtr = 16'hA5C3;
    sendFrame(16'h1234, 3'b101, 5'b11100, 24, stat(0, 0), "R2");  // K0..K4 = 00111
    rowPtr = 16'h0001;
    sendFrame(16'hFFFF, 3'b010, 5'b11110, 24, stat(0, 0), "R7");  // 01111 play
    sendFrame(16'h8001, 3'b111, 5'b10100, 24, stat(0, 0), "R6");  // 00101 setrec
    rowPtr = 16'h8000;
    sendFrame(16'h4321, 3'b000, 5'b10110, 24, stat(0, 0), "R6");  // 01101 rec
    sendFrame(16'h0F0F, 3'b000, 5'b00100, 24, stat(0, 0), "R6");  // 00100 powerup
    sendFrame(16'hBEEF, 3'b000, 5'b01110, 24, stat(0, 0), "R6");  // 01110 stop
    sendFrame(16'h0000, 3'b000, 5'b00110, 24, stat(0, 0), "R6");  // 01100 stop
    sendFrame(16'h2222, 3'b000, 5'b01011, 24, stat(0, 0), "R6");  // 11010 powerdown
    sendFrame(16'h3333, 3'b000, 5'b11101, 24, stat(0, 0), "R6");  // 10111 setcue
    sendFrame(16'h5555, 3'b000, 5'b11111, 24, stat(0, 0), "R6");  // 11111 cue
    // R8: cue with record
    sendFrame(16'h6666, 3'b000, 5'b10101, 24, stat(0, 0), "R8");  // 10101 -> setrec
    sendFrame(16'h7777, 3'b000, 5'b10111, 24, stat(0, 0), "R8");  // 11101 -> rec

    // R9: flags captured then cleared
    rowPtr = 16'h5A5A;
    @(negedge clk) ovfIn = 1'b1;
    @(negedge clk) ovfIn = 1'b0;
    #1 check(intPending === 1'b1, "R9", 32'(intPending), 1);
    sendFrame(16'h0000, 3'b000, 5'b00110, 24, stat(1, 0), "R9");
    check(intPending === 1'b0, "R9", 32'(intPending), 0);
    @(negedge clk) eomIn = 1'b1;
    @(negedge clk) eomIn = 1'b0;
    sendFrame(16'h0000, 3'b000, 5'b00110, 24, stat(0, 1), "R9");
    check(intPending === 1'b0, "R9", 32'(intPending), 0);

    // R10: short and long frames
    @(negedge clk) eomIn = 1'b1;
    @(negedge clk) eomIn = 1'b0;
    sendFrame(16'h1234, 3'b000, 5'b11100, 20, stat(0, 1), "R10");
    check(intPending === 1'b0, "R10", 32'(intPending), 0);
    sendFrame(16'h1234, 3'b000, 5'b11100, 25, stat(0, 0), "R10");
    sendFrame(16'hC0DE, 3'b000, 5'b11100, 24, stat(0, 0), "R10");

    waitClk(10);
    check(expQ.size() == 0, "R5", 32'(expQ.size()), 0);
    finishRun();
  end
endmodule